// File: doc/BRIEF.md
# Two-Requester Packet Bus Arbiter

This block lets two packet sources share one outbound link. Each source presents a packet one 36-bit beat at a time on a valid/ready input stream. A packet is 2 to 34 beats long, and its first two beats are a header. The body length (0 to 32 further beats) is read from bits [5:0] of the header's first beat. The arbiter grants one source at a time and sends that source's beats to the link through a single register stage. The output marks each beat valid and flags the first beat of each packet.

A source that loses arbitration is not turned away. Up to two of its header beats are accepted into a private two-entry holding register. After that, its ready is held low until it wins. When it wins, the held beats go out first and in arrival order, and then its remaining beats stream live. Grants take turns between the two sources at packet boundaries. A source asking alone is served at once.

Back-pressure rules: a beat moves on an input when valid and ready are both high at a clock edge. A source must keep valid and data steady while ready is low. Ready may depend on the other source's valid, but never the other way round. The link accepts every beat, so the output carries no ready.

Top module: `dual_pkt_arbiter`

## Requirements
- R1: A beat accepted live from the granted source appears on the bus exactly one cycle later, with its 36-bit data unchanged.
- R2: Packet length is the value in bits [5:0] of the first header beat plus two. Values above 32 count as 32, so a packet is never longer than 34 beats.
- R3: Beats of different packets never interleave. Each packet's beats leave in index order with no foreign beat between them. `bus_sop` is high only on the first beat of each packet and only together with `bus_valid`.
- R4: When both sources have traffic waiting at a packet boundary, the source that did not send the previous packet is granted next.
- R5: If both sources start a packet in the same cycle after reset, source 0 is granted first.
- R6: A source requesting while the other is idle is granted with no extra cycle: its first beat appears on the bus one cycle after acceptance.
- R7: A source that is not granted accepts at most two header beats. Its ready is low from the cycle after the second one is stored, and its third beat is accepted only in the cycle its second beat leaves on the bus.
- R8: On its grant, a source with stored header beats sends them first, in arrival order, then continues live, all in consecutive cycles when its valid stays high.
- R9: After reset the bus is idle and both sources see ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req0_valid | input | 1 | Source 0 beat valid |
| req0_ready | output | 1 | Source 0 beat accepted when high with valid |
| req0_data | input | 36 | Source 0 beat |
| req1_valid | input | 1 | Source 1 beat valid |
| req1_ready | output | 1 | Source 1 beat accepted when high with valid |
| req1_data | input | 36 | Source 1 beat |
| bus_valid | output | 1 | Link beat valid |
| bus_sop | output | 1 | First beat of a packet |
| bus_data | output | 36 | Link beat |

## Verification
Header capture for the waiting source can fall in the same cycle as live streaming for the granted one. A replay from the holding register can also start in the same cycle the other source begins a new packet. Both overlaps are provoked by sweeping body lengths on each side against start offsets of up to two cycles, so that packet ends line up with arrivals. They are judged by recording the acceptance cycle of every beat and the cycle it leaves on the bus, and then checking grant order, contiguity, the one-cycle path and the moment of the third-beat acceptance.

// File: rtl/pkt_arb_pkg.sv
package pkt_arb_pkg;
  localparam int BEAT_W   = 36;
  localparam int LEN_W    = 6;
  localparam int MAX_BODY = 32;
  localparam int HOLD_N   = 2;
endpackage

// File: rtl/pkt_hold.sv
module pkt_hold #(
  parameter int DW = pkt_arb_pkg::BEAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          clr,
  input  logic [DW-1:0] din,
  output logic [1:0]    cnt,
  output logic [DW-1:0] h0,
  output logic [DW-1:0] h1
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= 2'd0;
    else if (clr) cnt <= 2'd0;
    else if (cap) cnt <= cnt + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (cap && cnt == 2'd0) h0 <= din;
    if (cap && cnt == 2'd1) h1 <= din;
  end
endmodule

// File: rtl/pkt_arb_ctrl.sv
module pkt_arb_ctrl #(
  parameter int DW   = pkt_arb_pkg::BEAT_W,
  parameter int LW   = pkt_arb_pkg::LEN_W,
  parameter int MAXB = pkt_arb_pkg::MAX_BODY,
  localparam int CW  = $clog2(MAXB + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          in_valid,
  input  logic [1:0][DW-1:0]  in_data,
  input  logic [1:0][1:0]     hcnt,
  input  logic [1:0][DW-1:0]  hold0,
  input  logic [1:0][DW-1:0]  hold1,
  output logic [1:0]          in_ready,
  output logic [1:0]          cap,
  output logic [1:0]          clr,
  output logic                send,
  output logic                sop,
  output logic [DW-1:0]       send_data,
  output logic                busy,
  output logic                owner
);
  logic          busy_q, owner_q, rr_q;
  logic [CW-1:0] rem_q;
  logic [1:0]    rp_q, rp_sel, pend;
  logic          win, act, own, rpl, mine;
  logic [LW-1:0] fld;
  logic [CW-1:0] body;

  always_comb begin
    for (int i = 0; i < 2; i++) pend[i] = (hcnt[i] != 2'd0) || in_valid[i];
    win    = (pend == 2'b11) ? rr_q : pend[1];
    act    = busy_q || (pend != 2'b00);
    own    = busy_q ? owner_q : win;
    rp_sel = busy_q ? rp_q : 2'd0;
    rpl    = act && (rp_sel < hcnt[own]);
    if (rpl) send_data = (rp_sel == 2'd0) ? hold0[own] : hold1[own];
    else     send_data = in_data[own];
    send = rpl || (act && in_valid[own]);
    sop  = send && !busy_q;
    for (int i = 0; i < 2; i++) begin
      mine        = act && (own == 1'(i));
      in_ready[i] = mine ? !rpl : (hcnt[i] != 2'd2);
      cap[i]      = !mine && in_valid[i] && (hcnt[i] != 2'd2);
      clr[i]      = busy_q && (owner_q == 1'(i)) && send && (rem_q == CW'(1));
    end
    fld  = send_data[LW-1:0];
    body = (32'(fld) > MAXB) ? CW'(MAXB) : CW'(fld);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= 1'b0;
      rr_q    <= 1'b0;
      rem_q   <= '0;
      rp_q    <= 2'd0;
    end else if (sop) begin
      busy_q  <= 1'b1;
      owner_q <= win;
      rem_q   <= body + CW'(1);
      rp_q    <= rpl ? 2'd1 : 2'd0;
    end else if (busy_q && send) begin
      rem_q <= rem_q - CW'(1);
      if (rpl) rp_q <= rp_q + 2'd1;
      if (rem_q == CW'(1)) begin
        busy_q <= 1'b0;
        rr_q   <= ~owner_q;
        rp_q   <= 2'd0;
      end
    end
  end

  assign busy  = busy_q;
  assign owner = owner_q;
endmodule

// File: rtl/pkt_out_reg.sv
module pkt_out_reg #(
  parameter int DW = pkt_arb_pkg::BEAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          send,
  input  logic          sop,
  input  logic [DW-1:0] din,
  output logic          q_valid,
  output logic          q_sop,
  output logic [DW-1:0] q_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_sop   <= 1'b0;
    end else begin
      q_valid <= send;
      q_sop   <= sop;
    end
  end

  always_ff @(posedge clk) begin
    if (send) q_data <= din;
  end
endmodule

// File: rtl/dual_pkt_arbiter.sv
module dual_pkt_arbiter #(
  parameter int DW   = pkt_arb_pkg::BEAT_W,
  parameter int LW   = pkt_arb_pkg::LEN_W,
  parameter int MAXB = pkt_arb_pkg::MAX_BODY
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req0_valid,
  output logic          req0_ready,
  input  logic [DW-1:0] req0_data,
  input  logic          req1_valid,
  output logic          req1_ready,
  input  logic [DW-1:0] req1_data,
  output logic          bus_valid,
  output logic          bus_sop,
  output logic [DW-1:0] bus_data
);
  logic [1:0]          req_v, req_r, cap, clr;
  logic [1:0][DW-1:0]  in_d, hold0, hold1;
  logic [1:0][1:0]     hcnt;
  logic                send, sop, busy, owner;
  logic [DW-1:0]       send_data;

  assign req_v      = {req1_valid, req0_valid};
  assign in_d       = {req1_data, req0_data};
  assign req0_ready = req_r[0];
  assign req1_ready = req_r[1];

  for (genvar gi = 0; gi < 2; gi++) begin : g_hold
    pkt_hold #(.DW(DW)) u_hold (
      .clk(clk), .rst_n(rst_n), .cap(cap[gi]), .clr(clr[gi]),
      .din(in_d[gi]), .cnt(hcnt[gi]), .h0(hold0[gi]), .h1(hold1[gi])
    );
  end

  pkt_arb_ctrl #(.DW(DW), .LW(LW), .MAXB(MAXB)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(req_v), .in_data(in_d),
    .hcnt(hcnt), .hold0(hold0), .hold1(hold1), .in_ready(req_r),
    .cap(cap), .clr(clr), .send(send), .sop(sop), .send_data(send_data),
    .busy(busy), .owner(owner)
  );

  pkt_out_reg #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .send(send), .sop(sop), .din(send_data),
    .q_valid(bus_valid), .q_sop(bus_sop), .q_data(bus_data)
  );
endmodule

// File: rtl/dual_pkt_arbiter_chk.sv
module dual_pkt_arbiter_chk #(
  parameter int DW = pkt_arb_pkg::BEAT_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         req_valid,
  input logic [1:0]         req_ready,
  input logic [1:0][DW-1:0] req_data,
  input logic               bus_valid,
  input logic               bus_sop,
  input logic [DW-1:0]      bus_data,
  input logic               busy,
  input logic               owner,
  input logic [1:0][1:0]    hcnt
);
  AST_SOP_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sop |-> bus_valid); // R3
  AST_SOP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sop |-> !$past(busy)); // R3
  AST_OWNER_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (owner == $past(owner))); // R3
  AST_LIVE_ONE_STAGE0: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !owner && req_valid[0] && req_ready[0]) |=> (bus_valid && bus_data == $past(req_data[0]))); // R1
  AST_LIVE_ONE_STAGE1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && owner && req_valid[1] && req_ready[1]) |=> (bus_valid && bus_data == $past(req_data[1]))); // R1
  AST_FULL_STALLS0: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt[0] == 2'd2 && !(busy && !owner)) |-> !req_ready[0]); // R7
  AST_FULL_STALLS1: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt[1] == 2'd2 && !(busy && owner)) |-> !req_ready[1]); // R7
endmodule

bind dual_pkt_arbiter dual_pkt_arbiter_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_v), .req_ready(req_r),
  .req_data(in_d), .bus_valid(bus_valid), .bus_sop(bus_sop),
  .bus_data(bus_data), .busy(busy), .owner(owner), .hcnt(hcnt)
);

// File: tb/dual_pkt_arbiter_bench.sv
`timescale 1ns/1ps
module dual_pkt_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] v = 2'b00;
  logic [35:0] dat [2];
  logic [1:0] rdy;
  logic bv, bs;
  logic [35:0] bd;
  int checks = 0, errors = 0, cyc = 0;
  int acc_c [2][2][34];
  int out_c [2][2][34];
  int ord [8];
  int bodyv [2];
  int nsop, ncomp, cur_src, cur_pid, exp_idx, exp_tot;
  bit in_pkt, finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_pkt_arbiter u_dual_pkt_arbiter (
    .clk(clk), .rst_n(rst_n),
    .req0_valid(v[0]), .req0_ready(rdy[0]), .req0_data(dat[0]),
    .req1_valid(v[1]), .req1_ready(rdy[1]), .req1_data(dat[1]),
    .bus_valid(bv), .bus_sop(bs), .bus_data(bd)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int clampb(int b);
    return (b > 32) ? 32 : b;
  endfunction

  function automatic logic [35:0] mkword(int s, int pid, int j, int body);
    logic [5:0] low;
    low = (j == 0) ? 6'(body) : 6'(j);
    return {1'(s), 8'(pid), 6'(j), 15'(j * 37 + pid * 5 + s * 11), low};
  endfunction

  // Output monitor: ordering, content, no interleave (R2, R3, R8)
  always @(negedge clk) begin
    if (rst_n && bv) begin
      if (bs) begin
        chk(!in_pkt, "R2", in_pkt, 0);
        cur_src = int'(bd[35]);
        cur_pid = int'(bd[34:27]);
        chk(bd == mkword(cur_src, cur_pid, 0, bodyv[cur_src]), "R3", bd, mkword(cur_src, cur_pid, 0, bodyv[cur_src]));
        exp_tot = clampb(bodyv[cur_src]) + 2;
        if (nsop < 8) ord[nsop] = cur_src;
        nsop++;
        in_pkt = 1;
        exp_idx = 0;
      end else begin
        chk(in_pkt, "R3", in_pkt, 1);
        chk(bd == mkword(cur_src, cur_pid, exp_idx, bodyv[cur_src]), "R8", bd, mkword(cur_src, cur_pid, exp_idx, bodyv[cur_src]));
      end
      if (cur_pid < 2 && exp_idx < 34) out_c[cur_src][cur_pid][exp_idx] = cyc;
      exp_idx++;
      if (exp_idx == exp_tot) begin
        in_pkt = 0;
        ncomp++;
      end
    end
  end

  task automatic drv(int s, int body, int dl, int n, bit gap);
    int tot;
    bit acc;
    if (n == 0) return;
    repeat (dl) @(negedge clk);
    tot = clampb(body) + 2;
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < tot; j++) begin
        if (gap && s == 0 && j == 3) begin
          @(negedge clk);
          v[s] = 1'b0;
        end
        acc = 0;
        while (!acc) begin
          @(negedge clk);
          v[s] = 1'b1;
          dat[s] = mkword(s, k, j, body);
          #9;
          acc = rdy[s];
        end
        acc_c[s][k][j] = cyc;
      end
    end
    @(negedge clk);
    v[s] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    v = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    nsop = 0; ncomp = 0; in_pkt = 0; exp_idx = 0;
    #1;
    chk(bv == 1'b0, "R9", bv, 0);
    chk(rdy == 2'b11, "R9", rdy, 3);
  endtask

  task automatic run(int b0, int b1, int d0, int d1, int n0, int n1, bit gap);
    int wait_c, first;
    int ns [2];
    int bb [2];
    do_reset();
    bodyv[0] = b0; bodyv[1] = b1;
    ns[0] = n0; ns[1] = n1; bb[0] = b0; bb[1] = b1;
    fork
      drv(0, b0, d0, n0, gap);
      drv(1, b1, d1, n1, gap);
    join
    wait_c = 0;
    while (ncomp < n0 + n1 && wait_c < 300) begin
      @(negedge clk);
      wait_c++;
    end
    chk(ncomp == n0 + n1, "R3 (packets delivered)", ncomp, n0 + n1);
    if (n0 == 2 && n1 == 2) begin
      first = (d1 < d0) ? 1 : 0;
      for (int k = 0; k < 4; k++)
        chk(ord[k] == (first ^ (k & 1)), (k == 0 && d0 == d1) ? "R5" : "R4", ord[k], first ^ (k & 1));
    end
    if (n0 == 0) begin
      for (int k = 0; k < n1; k++) begin
        chk(ord[k] == 1, "R6", ord[k], 1);
        chk(out_c[1][k][0] == acc_c[1][k][0] + 1, "R6", out_c[1][k][0], acc_c[1][k][0] + 1);
      end
    end
    if (!gap) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < ns[s]; k++) begin
          int tot;
          tot = clampb(bb[s]) + 2;
          for (int j = 1; j < tot; j++)
            chk(out_c[s][k][j] == out_c[s][k][0] + j, "R8", out_c[s][k][j], out_c[s][k][0] + j);
          for (int j = 2; j < tot; j++)
            chk(out_c[s][k][j] == acc_c[s][k][j] + 1, "R1", out_c[s][k][j], acc_c[s][k][j] + 1);
          if (tot > 2 && out_c[s][k][0] > acc_c[s][k][0] + 1)
            chk(acc_c[s][k][2] == out_c[s][k][1], "R7", acc_c[s][k][2], out_c[s][k][1]);
        end
      end
    end
  endtask

  initial begin
    int bl [4];
    int dp [5][2];
    bl = '{0, 1, 3, 32};
    dp = '{'{0, 0}, '{0, 1}, '{0, 2}, '{1, 0}, '{2, 0}};
    dat[0] = '0; dat[1] = '0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int p = 0; p < 5; p++)
          run(bl[a], bl[b], dp[p][0], dp[p][1], 2, 2, 1'b0);
    run(0, 63, 0, 0, 0, 2, 1'b0);   // R2 clamp, R6 lone
    run(3, 3, 0, 0, 2, 2, 1'b1);    // bubbles on source 0
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule